// File: doc/BRIEF.md
# Parallel EEPROM Byte-Write Controller

This block sits on the host side of an asynchronous parallel EEPROM. It takes a single-cycle request made of an address, a data byte, a direction bit and a completion-mode bit. It then drives the chip-enable, write-strobe and output-enable pins, the address, and a data bus that it can release. Every interval the memory needs is a parameter in nanoseconds. The controller rounds each one up to whole clock cycles, with a floor of one cycle.

After a write strobe, the memory programs the byte on its own for several milliseconds. The controller detects the end of that programming in one of two ways, chosen per request. The first is to wait for the shared ready line to go high again. The second is to keep reading the written address until bit 7 returns the written value instead of its inverse. A write that does not finish within the timeout window ends with an error pulse, and the controller goes back to idle. A plain read request performs one timed read cycle and returns the byte.

Top module: `eewr_ctrl`

## Requirements
- R1: Out of reset, mem_ce_no, mem_we_no and mem_oe_no are high, mem_dq_oe_o is low, and busy_o, done_o and err_o are low.
- R2: A request (req_i high in a cycle where busy_o is low) is taken. A request made while busy_o is high has no effect: no write strobe is issued for it and the memory keeps its content. Each accepted request ends in exactly one cycle of done_o or err_o, never both, and busy_o is low in that cycle.
- R3: A write drives mem_we_no low for exactly max(WP, DS, AH) cycles, with mem_ce_no low. The address is stable for at least max(AS, OES) cycles before mem_we_no falls and stays stable while mem_ce_no is low.
- R4: mem_oe_no is high whenever mem_we_no is low. It is high for at least max(AS, OES) cycles before mem_we_no falls, and it stays high for at least max(DH, OEH) cycles after mem_we_no rises.
- R5: While mem_we_no is low, mem_dq_oe_o is high and mem_dq_o holds the request byte. The bus stays driven for at least DH cycles after mem_we_no rises.
- R6: mem_dq_oe_o is never high while mem_oe_no is low. After mem_oe_no rises, mem_dq_oe_o stays low for at least OHZ cycles.
- R7: With poll_mode_i=0 (ready-line mode), the controller waits the time-to-busy interval and then waits for mem_rdy_i (high = ready, low = programming). done_o only follows the line's return to high.
- R8: With poll_mode_i=1 (data polling), the controller repeats timed reads of the written address. It raises done_o after the first read whose bit 7 equals bit 7 of the written byte.
- R9: If a write is not complete TMO cycles after its strobe hold phase, err_o pulses instead of done_o and the controller returns to idle.
- R10: A read request (req_wr_i=0) drives mem_oe_no and mem_ce_no low for exactly RC cycles. It then floats the bus for OHZ cycles and pulses done_o, with rdata_o holding the byte sampled in the last access cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request strobe, taken when idle |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Request address |
| req_data_i | input | 8 | Write byte |
| poll_mode_i | input | 1 | 1 = data polling, 0 = ready line |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle timeout pulse |
| rdata_o | output | 8 | Last byte read |
| mem_addr_o | output | ADDR_W | Memory address pins |
| mem_ce_no | output | 1 | Chip enable, active low |
| mem_we_no | output | 1 | Write strobe, active low |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_dq_o | output | 8 | Data bus, host drive value |
| mem_dq_oe_o | output | 1 | Host drives data bus when high |
| mem_dq_i | input | 8 | Data bus as seen by host |
| mem_rdy_i | input | 1 | Shared ready line, low while programming |

## Verification
The assertions take for granted that mem_rdy_i and mem_dq_i come only from one memory that obeys the same pin protocol. They also take for granted that req_i is a plain synchronous strobe. The bench keeps to this by modelling a single memory that samples the pins away from the clock edge. The model latches the address when the strobe falls and the data when it rises, drops the ready line for a fixed programming time, and returns inverted bit 7 on reads of the written address during that time. The model can also be frozen busy, which forces both timeout paths.

// File: rtl/eewr_pkg.sv
package eewr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WSET, ST_WPUL, ST_WHLD, ST_WTDB, ST_WBSY, ST_RACC, ST_RFLT
  } st_e;

  function automatic int ns2cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/eewr_delay.sv
module eewr_delay #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/eewr_wdog.sv
module eewr_wdog #(
  parameter int LIMIT = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic hit_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i)           cnt_q <= '0;
    else if (run_i && !hit_o) cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o = (cnt_q >= LIM);
endmodule

// File: rtl/eewr_sync.sv
module eewr_sync #(
  parameter int    STAGES  = 2,
  parameter logic  RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= {STAGES{RST_VAL}};
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/eewr_ctrl.sv
module eewr_ctrl
  import eewr_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int CLK_NS    = 10,
  parameter int T_AS_NS   = 10,
  parameter int T_AH_NS   = 100,
  parameter int T_WP_NS   = 150,
  parameter int T_DS_NS   = 50,
  parameter int T_DH_NS   = 10,
  parameter int T_OES_NS  = 15,
  parameter int T_OEH_NS  = 15,
  parameter int T_RC_NS   = 200,
  parameter int T_OHZ_NS  = 55,
  parameter int T_DB_NS   = 80,
  parameter int TMO_NS    = 12_000_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              req_wr_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [7:0]        req_data_i,
  input  logic              poll_mode_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [7:0]        rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce_no,
  output logic              mem_we_no,
  output logic              mem_oe_no,
  output logic [7:0]        mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [7:0]        mem_dq_i,
  input  logic              mem_rdy_i
);
  localparam int SET_C = imax(ns2cyc(T_AS_NS, CLK_NS), ns2cyc(T_OES_NS, CLK_NS));
  localparam int PUL_C = imax(imax(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_DS_NS, CLK_NS)),
                              ns2cyc(T_AH_NS, CLK_NS));
  localparam int HLD_C = imax(ns2cyc(T_DH_NS, CLK_NS), ns2cyc(T_OEH_NS, CLK_NS));
  localparam int RD_C  = ns2cyc(T_RC_NS, CLK_NS);
  localparam int HZ_C  = ns2cyc(T_OHZ_NS, CLK_NS);
  localparam int DB_C  = ns2cyc(T_DB_NS, CLK_NS) + 2; // covers ready-line synchronizer
  localparam int TMO_C = ns2cyc(TMO_NS, CLK_NS);
  localparam int MAX_C = imax(imax(imax(SET_C, PUL_C), imax(HLD_C, RD_C)), imax(HZ_C, DB_C));
  localparam int DW    = $clog2(MAX_C + 1);

  localparam logic [DW-1:0] SET_V = DW'(SET_C - 1);
  localparam logic [DW-1:0] PUL_V = DW'(PUL_C - 1);
  localparam logic [DW-1:0] HLD_V = DW'(HLD_C - 1);
  localparam logic [DW-1:0] RD_V  = DW'(RD_C - 1);
  localparam logic [DW-1:0] HZ_V  = DW'(HZ_C - 1);
  localparam logic [DW-1:0] DB_V  = DW'(DB_C - 1);

  st_e               st_q, st_d;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        wd_q, rd_q;
  logic              mode_q, poll_q;
  logic              ld;
  logic [DW-1:0]     ld_v;
  logic              dly_zero, tmo_hit, rdy_s;
  logic              fin_ok, fin_err, to_poll, wd_run;

  eewr_delay #(.W(DW)) u_dly (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(ld), .val_i(ld_v), .zero_o(dly_zero)
  );

  assign wd_run = (st_q == ST_WTDB) || (st_q == ST_WBSY) ||
                  (poll_q && ((st_q == ST_RACC) || (st_q == ST_RFLT)));

  eewr_wdog #(.LIMIT(TMO_C)) u_wdog (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(st_q == ST_WHLD), .run_i(wd_run), .hit_o(tmo_hit)
  );

  eewr_sync #(.STAGES(2), .RST_VAL(1'b1)) u_rdy_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(mem_rdy_i), .q_o(rdy_s)
  );

  always_comb begin
    st_d    = st_q;
    ld      = 1'b0;
    ld_v    = '0;
    fin_ok  = 1'b0;
    fin_err = 1'b0;
    to_poll = 1'b0;
    unique case (st_q)
      ST_IDLE: if (req_i) begin
        ld = 1'b1;
        if (req_wr_i) begin st_d = ST_WSET; ld_v = SET_V; end
        else          begin st_d = ST_RACC; ld_v = RD_V;  end
      end
      ST_WSET: if (dly_zero) begin st_d = ST_WPUL; ld = 1'b1; ld_v = PUL_V; end
      ST_WPUL: if (dly_zero) begin st_d = ST_WHLD; ld = 1'b1; ld_v = HLD_V; end
      ST_WHLD: if (dly_zero) begin st_d = ST_WTDB; ld = 1'b1; ld_v = DB_V;  end
      ST_WTDB: if (dly_zero) begin
        if (mode_q) begin st_d = ST_RACC; ld = 1'b1; ld_v = RD_V; to_poll = 1'b1; end
        else        st_d = ST_WBSY;
      end
      ST_WBSY: begin
        if (rdy_s)        begin fin_ok  = 1'b1; st_d = ST_IDLE; end
        else if (tmo_hit) begin fin_err = 1'b1; st_d = ST_IDLE; end
      end
      ST_RACC: if (dly_zero) begin st_d = ST_RFLT; ld = 1'b1; ld_v = HZ_V; end
      ST_RFLT: if (dly_zero) begin
        if (!poll_q || (rd_q[7] == wd_q[7])) begin fin_ok = 1'b1; st_d = ST_IDLE; end
        else if (tmo_hit)                    begin fin_err = 1'b1; st_d = ST_IDLE; end
        else begin st_d = ST_RACC; ld = 1'b1; ld_v = RD_V; end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      wd_q   <= '0;
      rd_q   <= '0;
      mode_q <= 1'b0;
      poll_q <= 1'b0;
      done_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_o <= fin_ok;
      err_o  <= fin_err;
      if (st_q == ST_IDLE && req_i) begin
        addr_q <= req_addr_i;
        wd_q   <= req_data_i;
        mode_q <= poll_mode_i;
        poll_q <= 1'b0;
      end
      if (to_poll) poll_q <= 1'b1;
      if (st_q == ST_RACC && dly_zero) rd_q <= mem_dq_i;
    end
  end

  assign busy_o      = (st_q != ST_IDLE);
  assign rdata_o     = rd_q;
  assign mem_addr_o  = addr_q;
  assign mem_dq_o    = wd_q;
  assign mem_ce_no   = !((st_q == ST_WSET) || (st_q == ST_WPUL) ||
                         (st_q == ST_WHLD) || (st_q == ST_RACC));
  assign mem_we_no   = (st_q != ST_WPUL);
  assign mem_oe_no   = (st_q != ST_RACC);
  assign mem_dq_oe_o = (st_q == ST_WSET) || (st_q == ST_WPUL) || (st_q == ST_WHLD);

  // R4
  oe_we_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> mem_oe_no);
  // R6
  no_contention_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_no |-> !mem_dq_oe_o);
  // R3
  addr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_ce_no && $past(!mem_ce_no)) |-> $stable(mem_addr_o));
  // R5
  data_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> (mem_dq_oe_o && $stable(mem_dq_o)));
  // R9
  done_err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !done_o);
  // R2
  result_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || err_o) |-> !busy_o);
  // R7
  rdy_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !poll_q && $past(st_q == ST_WBSY)) |-> $past(rdy_s));
endmodule

// File: tb/eewr_ctrl_tb_top.sv
module eewr_ctrl_tb_top;
  localparam int AW     = 11;
  localparam int CLK    = 10;
  localparam int TMO_NS = 8000;
  localparam int WR_CYC = 300;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK - 1) / CLK;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int SET_C = 2;   // max(10ns,15ns) at 10 ns
  localparam int PUL_C = 15;  // max(150,50,100) ns
  localparam int HLD_C = 2;   // max(10,15) ns
  localparam int DH_C  = 1;
  localparam int RD_C  = 20;
  localparam int HZ_C  = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, req_wr = 1'b0, pmode = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]    req_data = '0;
  logic          busy, done, err;
  logic [7:0]    rdata;
  logic [AW-1:0] m_addr;
  logic          m_ce, m_we, m_oe, m_dqoe, m_rdy;
  logic [7:0]    m_dqo, m_dqi;

  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  eewr_ctrl #(.ADDR_W(AW), .CLK_NS(CLK), .TMO_NS(TMO_NS)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_wr_i(req_wr), .req_addr_i(req_addr),
    .req_data_i(req_data), .poll_mode_i(pmode), .busy_o(busy), .done_o(done), .err_o(err),
    .rdata_o(rdata), .mem_addr_o(m_addr), .mem_ce_no(m_ce), .mem_we_no(m_we),
    .mem_oe_no(m_oe), .mem_dq_o(m_dqo), .mem_dq_oe_o(m_dqoe), .mem_dq_i(m_dqi),
    .mem_rdy_i(m_rdy)
  );

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // memory model
  logic [7:0]    mem [2048];
  logic [AW-1:0] lat_addr = '0, last_addr = '0;
  logic [7:0]    last_data = '0;
  int            busy_cnt = 0, n_writes = 0;
  bit            stuck = 1'b0;
  logic          p_we = 1'b1, p_oe = 1'b1, p_dqoe = 1'b0;
  logic [AW-1:0] p_addr = '0;

  assign m_rdy = (busy_cnt == 0);
  assign m_dqi = (!m_ce && !m_oe) ?
                 ((busy_cnt != 0 && m_addr == last_addr) ? {~last_data[7], 7'h2A} : mem[m_addr])
                 : 8'h00;

  // protocol reference, evaluated every clock
  logic [AW-1:0] exp_waddr = '0;
  logic [7:0]    exp_wdata = '0;
  int we_run = 0, oe_lo_run = 0, oe_hi_run = 1000, addr_stab = 1000;
  int since_we_rise = 1000, since_oe_rise = 1000, oe_falls = 0;
  logic [AW-1:0] last_rd_addr = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!m_we && p_we && !m_ce) lat_addr = m_addr;
      if (m_we && !p_we && !m_ce) begin
        mem[lat_addr] = m_dqo;
        last_addr = lat_addr;
        last_data = m_dqo;
        busy_cnt = WR_CYC;
        n_writes++;
      end else if (busy_cnt > 0 && !stuck) busy_cnt--;

      if (!m_we && p_we) begin
        chk(oe_hi_run >= SET_C, "R4", "OE high before WE fall", oe_hi_run, SET_C);
        chk(addr_stab >= SET_C, "R3", "addr setup cycles", addr_stab, SET_C);
      end
      if (m_we && !p_we) chk(we_run == PUL_C, "R3", "WE low width", we_run, PUL_C);
      if (!m_we) begin
        chk(m_oe && !m_ce && m_dqoe, "R5", "pins during WE low", {m_oe, m_ce, m_dqoe}, 3'b101);
        chk(m_dqo == exp_wdata, "R5", "data during WE low", m_dqo, exp_wdata);
        chk(m_addr == exp_waddr, "R3", "addr during WE low", m_addr, exp_waddr);
      end
      if (!m_oe && p_oe) begin
        oe_falls++;
        last_rd_addr = m_addr;
        chk(since_we_rise >= HLD_C, "R4", "OE hold after WE rise", since_we_rise, HLD_C);
      end
      if (m_oe && !p_oe) chk(oe_lo_run == RD_C, "R10", "OE low width", oe_lo_run, RD_C);
      if (!m_oe) chk(!m_dqoe, "R6", "bus driven with OE low", m_dqoe, 0);
      if (m_dqoe && !p_dqoe) chk(since_oe_rise >= HZ_C, "R6", "float after OE rise", since_oe_rise, HZ_C);
      if (!m_dqoe && p_dqoe) chk(since_we_rise >= DH_C, "R5", "data hold", since_we_rise, DH_C);

      we_run        = !m_we ? (p_we ? 1 : we_run + 1) : 0;
      oe_lo_run     = !m_oe ? (p_oe ? 1 : oe_lo_run + 1) : 0;
      oe_hi_run     = m_oe ? (p_oe ? oe_hi_run + 1 : 1) : 0;
      addr_stab     = (m_addr == p_addr) ? addr_stab + 1 : 1;
      since_we_rise = (m_we && !p_we) ? 1 : mx(since_we_rise + 1, 0);
      since_oe_rise = (m_oe && !p_oe) ? 1 : since_oe_rise + 1;
      if (since_we_rise > 100000) since_we_rise = 100000;
      if (since_oe_rise > 100000) since_oe_rise = 100000;
      if (addr_stab > 100000) addr_stab = 100000;
      if (oe_hi_run > 100000) oe_hi_run = 100000;
      p_we = m_we; p_oe = m_oe; p_dqoe = m_dqoe; p_addr = m_addr;
    end
  end

  task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [7:0] d, input bit pm);
    @(negedge clk);
    if (wr) begin exp_waddr = a; exp_wdata = d; end
    req = 1'b1; req_wr = wr; req_addr = a; req_data = d; pmode = pm;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wait_end(output bit d, output bit e, output int cycles, output bit b);
    d = 0; e = 0; cycles = 0; b = 1;
    while (!done && !err && cycles < 5000) begin
      @(negedge clk);
      cycles++;
    end
    d = done; e = err; b = busy;
  endtask

  bit d, e, b;
  int cy, w0, f0;

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(m_ce && m_we && m_oe && !m_dqoe, "R1", "pins in reset", {m_ce, m_we, m_oe, m_dqoe}, 4'b1110);
    chk(!busy && !done && !err, "R1", "status in reset", {busy, done, err}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(m_ce && m_we && m_oe && !m_dqoe && !busy, "R1", "idle after reset", {m_ce, m_we, m_oe, m_dqoe, busy}, 5'b11100);

    // R7 ready-line write
    w0 = n_writes;
    issue(1, 11'h123, 8'hA5, 0);
    wait_end(d, e, cy, b);
    chk(d && !e && !b, "R7", "ready-line write result", {d, e, b}, 3'b100);
    chk(busy_cnt == 0, "R7", "done before programming end", busy_cnt, 0);
    chk(cy >= WR_CYC, "R7", "completion latency", cy, WR_CYC);
    chk(n_writes == w0 + 1, "R2", "one strobe per write", n_writes - w0, 1);

    // R10 read back
    issue(0, 11'h123, 8'h00, 0);
    wait_end(d, e, cy, b);
    chk(d && !e, "R10", "read result", {d, e}, 2'b10);
    chk(rdata == 8'hA5, "R10", "read data", rdata, 8'hA5);
    chk(cy == RD_C + HZ_C, "R10", "read latency", cy, RD_C + HZ_C);

    // R8 polling, written bit7 = 0
    f0 = oe_falls;
    issue(1, 11'h7FF, 8'h3C, 1);
    wait_end(d, e, cy, b);
    chk(d && !e, "R8", "poll write result", {d, e}, 2'b10);
    chk(busy_cnt == 0, "R8", "poll done only after programming", busy_cnt, 0);
    chk(oe_falls - f0 >= 2, "R8", "repeated poll reads", oe_falls - f0, 2);
    chk(last_rd_addr == 11'h7FF, "R8", "poll address", last_rd_addr, 11'h7FF);
    chk(rdata == 8'h3C, "R8", "final poll data", rdata, 8'h3C);

    // R8 polling, written bit7 = 1
    issue(1, 11'h000, 8'h80, 1);
    wait_end(d, e, cy, b);
    chk(d && !e && busy_cnt == 0, "R8", "poll bit7=1 result", {d, e}, 2'b10);
    chk(mem[0] == 8'h80, "R3", "stored byte", mem[0], 8'h80);

    // R2 request while busy is ignored
    w0 = n_writes;
    issue(1, 11'h010, 8'h11, 0);
    repeat (30) @(negedge clk);
    req = 1'b1; req_wr = 1'b1; req_addr = 11'h020; req_data = 8'h22; pmode = 1'b1;
    @(negedge clk);
    req = 1'b0;
    wait_end(d, e, cy, b);
    chk(d && !e, "R2", "first request result", {d, e}, 2'b10);
    repeat (3) @(negedge clk);
    chk(!busy && !done, "R2", "no second operation", {busy, done}, 0);
    chk(n_writes == w0 + 1, "R2", "strobes for ignored request", n_writes - w0, 1);
    issue(0, 11'h020, 8'h00, 0);
    wait_end(d, e, cy, b);
    chk(rdata == 8'hFF, "R2", "ignored address untouched", rdata, 8'hFF);

    // R9 timeout, ready-line mode
    stuck = 1'b1;
    issue(1, 11'h055, 8'h5A, 0);
    wait_end(d, e, cy, b);
    chk(!d && e && !b, "R9", "ready-line timeout", {d, e, b}, 3'b010);
    chk(cy >= cyc(TMO_NS), "R9", "timeout latency", cy, cyc(TMO_NS));
    #1; busy_cnt = 0;
    repeat (5) @(negedge clk);

    // R9 timeout, polling mode
    issue(1, 11'h056, 8'hC3, 1);
    wait_end(d, e, cy, b);
    chk(!d && e && !b, "R9", "poll timeout", {d, e, b}, 3'b010);
    chk(cy >= cyc(TMO_NS), "R9", "poll timeout latency", cy, cyc(TMO_NS));
    #1; stuck = 1'b0; busy_cnt = 0;
    repeat (5) @(negedge clk);

    // R6 read then immediate write: bus turnaround
    issue(0, 11'h7FF, 8'h00, 0);
    wait_end(d, e, cy, b);
    chk(rdata == 8'h3C, "R10", "read of earlier write", rdata, 8'h3C);
    issue(1, 11'h3A0, 8'h69, 0);
    wait_end(d, e, cy, b);
    chk(d && !e, "R6", "write after read", {d, e}, 2'b10);

    repeat (5) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule